// File: doc/BRIEF.md
# Dual-Lane Bidirectional Bus Transceiver Datapath

This block moves data in both directions between two wide ports, called A and B, split into independent byte lanes. Each lane carries a storage element per direction. That element can pass data straight through, freeze the value present when its latch enable drops, or capture data on each rising clock edge while the latch enable stays low. Every lane has its own latch enables and active-low drive enables for each direction. A single clock and a single active-low global enable are shared by all lanes.

Each pad is modelled as three vectors. An input vector carries the external bus value. An output vector carries the value the block would drive. An active-high drive-enable vector has one bit per pin. Board logic or a testbench combines the three into a resolved bus. The data that feeds one direction is always the input vector of the opposite port.

Top module: `ubt_xcvr`

## Requirements
- R1: While `le_ab` of a lane is 1, that lane's `b_out` equals its `a_in` and follows it without waiting for a clock edge.
- R2: When `le_ab` of a lane falls from 1 to 0, the `a_in` value present at that moment is held on `b_out` until the next rising `clk` edge, whether `clk` was high or low when the enable fell.
- R3: While `le_ab` of a lane is 0, each rising `clk` edge loads that lane's `a_in` into the storage element, and the loaded value appears on `b_out`.
- R4: While `le_ab` of a lane stays 0 and no rising `clk` edge occurs, `b_out` keeps its value through changes of `a_in`, with `clk` either high or low.
- R5: The B-to-A direction behaves as in R1 to R4, using `le_ba`, `b_in` and `a_out`.
- R6: With `oe_n` = 0, `b_drv` bits of a lane are all 1 when that lane's `oeab_n` is 0 and all 0 when it is 1.
- R7: With `oe_n` = 0, `a_drv` bits of a lane are all 1 when that lane's `oeba_n` is 0 and all 0 when it is 1.
- R8: With `oe_n` = 1, every bit of `a_drv` and `b_drv` is 0, whatever the per-lane enables are.
- R9: The enables of one lane have no effect on the data or drive outputs of any other lane. Lane k occupies bits [8k+7:8k].
- R10: Reset (`rst_n` = 0, asynchronous) clears every storage element to zero, so a lane with its latch enable at 0 outputs 0 after reset until the first clock load.
- R11: When both `oeab_n` and `oeba_n` of a lane are 0, both ports of that lane drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all storage |
| oe_n | input | 1 | Global active-low drive enable for both ports of all lanes |
| le_ab | input | LANES | Per-lane latch enable, A-to-B direction |
| le_ba | input | LANES | Per-lane latch enable, B-to-A direction |
| oeab_n | input | LANES | Per-lane active-low drive enable for port B |
| oeba_n | input | LANES | Per-lane active-low drive enable for port A |
| a_in | input | LANES*LANE_W | Value seen on the A bus |
| a_out | output | LANES*LANE_W | Value offered to the A bus |
| a_drv | output | LANES*LANE_W | Per-pin drive enable for the A bus |
| b_in | input | LANES*LANE_W | Value seen on the B bus |
| b_out | output | LANES*LANE_W | Value offered to the B bus |
| b_drv | output | LANES*LANE_W | Per-pin drive enable for the B bus |

## Verification
The bench builds the block with its defaults: two lanes of eight bits. With two lanes, every check that changes one lane can also confirm that the other lane did not move. This covers lanes in different modes at the same time, and each drive-enable combination set against a fixed neighbour. Eight-bit lanes let each scenario use distinct byte patterns per lane and per direction, so a crossed lane or a crossed direction shows up as a wrong value, not as a coincidental match.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_LATCHED = 2'd1,
    MODE_CLOCKED = 2'd2
  } hold_mode_e;

  function automatic logic port_drive(input logic glob_oe_n, input logic dir_oe_n);
    return !glob_oe_n && !dir_oe_n;
  endfunction

  function automatic hold_mode_e pick_mode(input logic le, input logic clocked);
    if (le)
      return MODE_PASS;
    else if (clocked)
      return MODE_CLOCKED;
    else
      return MODE_LATCHED;
  endfunction

endpackage

// File: rtl/ubt_hold_cell.sv
module ubt_hold_cell
  import ubt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output hold_mode_e   mode
);

  logic [W-1:0] lat_q;
  logic [W-1:0] reg_q;
  logic         reg_live;

  always_latch begin
    if (!rst_n)
      lat_q <= '0;
    else if (le)
      lat_q <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_q <= '0;
    else if (!le)
      reg_q <= d;
  end

  always_ff @(posedge clk or posedge le or negedge rst_n) begin
    if (!rst_n)
      reg_live <= 1'b0;
    else if (le)
      reg_live <= 1'b0;
    else
      reg_live <= 1'b1;
  end

  assign mode = pick_mode(le, reg_live);

  always_comb begin
    unique case (mode)
      MODE_PASS:    q = d;
      MODE_CLOCKED: q = reg_q;
      default:      q = lat_q;
    endcase
  end

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
  import ubt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glob_oe_n,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         oeab_n,
  input  logic         oeba_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_drv,
  output hold_mode_e   mode_ab,
  output hold_mode_e   mode_ba
);

  ubt_hold_cell #(.W(W)) u_ab (
    .clk  (clk),
    .rst_n(rst_n),
    .le   (le_ab),
    .d    (a_in),
    .q    (b_out),
    .mode (mode_ab)
  );

  ubt_hold_cell #(.W(W)) u_ba (
    .clk  (clk),
    .rst_n(rst_n),
    .le   (le_ba),
    .d    (b_in),
    .q    (a_out),
    .mode (mode_ba)
  );

  assign b_drv = {W{port_drive(glob_oe_n, oeab_n)}};
  assign a_drv = {W{port_drive(glob_oe_n, oeba_n)}};

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        le_ab,
  input  logic [LANES-1:0]        le_ba,
  input  logic [LANES-1:0]        oeab_n,
  input  logic [LANES-1:0]        oeba_n,
  input  logic [LANES*LANE_W-1:0] a_in,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES*LANE_W-1:0] a_drv,
  input  logic [LANES*LANE_W-1:0] b_in,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES*LANE_W-1:0] b_drv
);

  hold_mode_e lane_mode_ab [LANES];
  hold_mode_e lane_mode_ba [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ubt_lane #(.W(LANE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .glob_oe_n(oe_n),
      .le_ab    (le_ab[g]),
      .le_ba    (le_ba[g]),
      .oeab_n   (oeab_n[g]),
      .oeba_n   (oeba_n[g]),
      .a_in     (a_in[g*LANE_W +: LANE_W]),
      .b_in     (b_in[g*LANE_W +: LANE_W]),
      .a_out    (a_out[g*LANE_W +: LANE_W]),
      .b_out    (b_out[g*LANE_W +: LANE_W]),
      .a_drv    (a_drv[g*LANE_W +: LANE_W]),
      .b_drv    (b_drv[g*LANE_W +: LANE_W]),
      .mode_ab  (lane_mode_ab[g]),
      .mode_ba  (lane_mode_ba[g])
    );
  end

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk
  import ubt_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    oe_n,
  input logic [LANES-1:0]        le_ab,
  input logic [LANES-1:0]        le_ba,
  input logic [LANES-1:0]        oeab_n,
  input logic [LANES-1:0]        oeba_n,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES*LANE_W-1:0] a_drv,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES*LANE_W-1:0] b_drv,
  input hold_mode_e              lane_mode_ab [LANES],
  input hold_mode_e              lane_mode_ba [LANES]
);

  assert_global_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_drv == '0 && b_drv == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_pass_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
      le_ab[g] |-> b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]);

    assert_load_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(le_ab[g]) && !le_ab[g])
        |-> (b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])
             && lane_mode_ab[g] == MODE_CLOCKED));

    assert_pass_ba_R5: assert property (@(posedge clk) disable iff (!rst_n)
      le_ba[g] |-> a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]);

    assert_load_ba_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(le_ba[g]) && !le_ba[g])
        |-> (a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])
             && lane_mode_ba[g] == MODE_CLOCKED));

    assert_bdrv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n) |-> (oeab_n[g] ? (b_drv[g*LANE_W +: LANE_W] == '0)
                             : (&b_drv[g*LANE_W +: LANE_W])));

    assert_adrv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n) |-> (oeba_n[g] ? (a_drv[g*LANE_W +: LANE_W] == '0)
                             : (&a_drv[g*LANE_W +: LANE_W])));
  end

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
  localparam int LANES = 2;
  localparam int W     = 8;
  localparam int N     = LANES * W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             oe_n = 1'b0;
  logic [LANES-1:0] le_ab = '0, le_ba = '0, oeab_n = '0, oeba_n = '0;
  logic [N-1:0]     a_ext = '1, b_ext = '1;
  logic [N-1:0]     a_out, a_drv, b_out, b_drv;
  int               n_chk = 0, n_bad = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;

  ubt_xcvr #(.LANES(LANES), .LANE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n),
    .le_ab(le_ab), .le_ba(le_ba), .oeab_n(oeab_n), .oeba_n(oeba_n),
    .a_in(a_ext), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_ext), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lane_of(input logic [N-1:0] v, input int l);
    return N'(v[l*W +: W]);
  endfunction

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2;
    chk("R10 b_out in reset", b_out, '0);
    chk("R10 a_out in reset", a_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R10 b_out after release", b_out, '0);
    chk("R10 a_out after release", a_out, '0);
  endtask

  task automatic t_pass(input int l);
    @(negedge clk); #2;
    le_ab[l] = 1'b1; le_ba[l] = 1'b1;
    a_ext[l*W +: W] = 8'h5A; b_ext[l*W +: W] = 8'hC3;
    #1;
    chk("R1 pass A to B", lane_of(b_out, l), N'(8'h5A));
    chk("R5 pass B to A", lane_of(a_out, l), N'(8'hC3));
    #2;
    a_ext[l*W +: W] = 8'h96;
    #1;
    chk("R1 follow A change", lane_of(b_out, l), N'(8'h96));
  endtask

  task automatic t_fall(input int l, input bit high_phase);
    @(negedge clk); #2;
    le_ab[l] = 1'b1; le_ba[l] = 1'b1;
    if (high_phase) @(posedge clk); else @(negedge clk);
    #3;
    a_ext[l*W +: W] = 8'h3E; b_ext[l*W +: W] = 8'h71;
    #1;
    le_ab[l] = 1'b0; le_ba[l] = 1'b0;
    #1;
    a_ext[l*W +: W] = 8'hE3; b_ext[l*W +: W] = 8'h17;
    #2;
    chk(high_phase ? "R2 fall with clk high" : "R2 fall with clk low",
        lane_of(b_out, l), N'(8'h3E));
    chk("R5 B to A fall hold", lane_of(a_out, l), N'(8'h71));
  endtask

  task automatic t_clock(input int l);
    @(negedge clk); #2;
    le_ab[l] = 1'b0; le_ba[l] = 1'b0;
    a_ext[l*W +: W] = 8'h4B; b_ext[l*W +: W] = 8'hD2;
    @(posedge clk); #2;
    chk("R3 edge load A to B", lane_of(b_out, l), N'(8'h4B));
    chk("R5 edge load B to A", lane_of(a_out, l), N'(8'hD2));
    a_ext[l*W +: W] = 8'hB4; b_ext[l*W +: W] = 8'h2D;
    #3;
    chk("R4 hold clk high", lane_of(b_out, l), N'(8'h4B));
    @(negedge clk); #3;
    chk("R4 hold clk low", lane_of(b_out, l), N'(8'h4B));
    chk("R5 hold clk low", lane_of(a_out, l), N'(8'hD2));
    @(posedge clk); #2;
    chk("R3 second edge load", lane_of(b_out, l), N'(8'hB4));
  endtask

  task automatic t_drive(input int l);
    int o = (l + 1) % LANES;
    @(negedge clk); #2;
    oe_n = 1'b0; oeab_n[o] = 1'b0; oeba_n[o] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      oeab_n[l] = k[0]; oeba_n[l] = k[1];
      #1;
      chk("R6 B drive per lane", lane_of(b_drv, l), k[0] ? N'(0) : N'(8'hFF));
      chk("R7 A drive per lane", lane_of(a_drv, l), k[1] ? N'(0) : N'(8'hFF));
      if (k == 0)
        chk("R11 both ports drive", lane_of(a_drv & b_drv, l), N'(8'hFF));
      chk("R9 other lane B drive", lane_of(b_drv, o), N'(8'hFF));
      chk("R9 other lane A drive", lane_of(a_drv, o), N'(0));
    end
    oeab_n = '0; oeba_n = '0;
    oe_n = 1'b1;
    #1;
    chk("R8 global off A", a_drv, '0);
    chk("R8 global off B", b_drv, '0);
    oe_n = 1'b0;
    #1;
    chk("R6 drive restored", b_drv, '1);
  endtask

  task automatic t_indep();
    @(negedge clk); #2;
    le_ab[0] = 1'b1; le_ab[1] = 1'b0;
    a_ext = 16'h2211;
    @(posedge clk); #2;
    a_ext = 16'h8877;
    #1;
    chk("R9 lane0 transparent", lane_of(b_out, 0), N'(8'h77));
    chk("R9 lane1 holds", lane_of(b_out, 1), N'(8'h22));
    le_ab = '0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    t_reset();
    for (int l = 0; l < LANES; l++) begin
      t_pass(l);
      t_fall(l, 1'b1);
      t_fall(l, 1'b0);
      t_clock(l);
      t_drive(l);
    end
    t_indep();
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_up();
  end

endmodule